// File: doc/BRIEF.md
# Fan Tachometer Period Counter

The block measures how fast a fan turns by counting a slow reference tick across one tachometer period. The raw tach line comes in asynchronously, so it is passed through a two-flop synchronizer and a sample-count debouncer. Counting runs from one accepted rising edge to the next. With two tach pulses per revolution and a 50 kHz tick, the latched count equals 1,500,000 divided by the speed in RPM. A bigger number therefore means a slower fan. Conversion to RPM is left to software.

The running count stops at 4095. A count of 4095 means the fan is too slow to measure, which is roughly 366 RPM and below. The value is latched the moment the count reaches full scale, so a stalled fan gets reported without waiting for an edge that may never arrive. A low-speed alarm is raised in two cases: when the latched count is above a programmable limit, or when it sits at full scale. The first period after reset is incomplete, so it is thrown away.

Top module: `fan_tach_meter`

## Requirements
- R1: While reset is asserted, and after it is released until a result exists, count_out is 0, count_valid is 0 and slow_alarm is 0.
- R2: The tach input is synchronized by two flops, and a new level is accepted only after DEB_LEN (default 3) consecutive clock samples that differ from the current level. A pulse of DEB_LEN-1 or fewer cycles, of either polarity, produces no edge and does not split the period being measured.
- R3: One period is the number of ref_tick pulses (single-cycle high strobes) seen between two consecutive accepted rising edges. That number is latched into count_out when the closing edge is accepted, and the count of the new period starts from zero.
- R4: The span from reset to the first accepted rising edge is discarded. count_valid stays 0 until a second accepted rising edge, or until the count saturates.
- R5: Once count_valid is 1, it stays 1 until reset.
- R6: When the running count reaches 4095 before the next accepted edge, count_out becomes 4095 at once and count_valid becomes 1. Further ticks do not move the count. The next accepted edge latches 4095 again and restarts counting from zero.
- R7: slow_alarm is 1 when count_valid is 1 and count_out is greater than spd_limit, compared as unsigned numbers. When count_out equals spd_limit, there is no alarm. The alarm follows a change of spd_limit in the same cycle.
- R8: slow_alarm is 1 whenever count_valid is 1 and count_out is 4095, whatever the value of spd_limit, including 4095.
- R9: count_out changes only in the cycle after an accepted edge or a ref_tick. While neither occurs, it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tach_in | input | 1 | Raw asynchronous tachometer signal |
| ref_tick | input | 1 | One-cycle strobe of the reference tick (50 kHz nominal) |
| spd_limit | input | CNT_W | Minimum-speed limit expressed as a count; a larger count is slower |
| count_out | output | CNT_W | Latched period count, full scale marks a stalled fan |
| count_valid | output | 1 | A complete or saturated measurement is held in count_out |
| slow_alarm | output | 1 | Fan slower than the limit or too slow to measure |

## Verification
The bench drives tach glitches exactly one cycle shorter than the debounce length, in both polarities. A debouncer that accepts them would cut the period short and report a small count. It runs one period of 4094 ticks and one long enough to pass 4095. An off-by-one in saturation would either latch 4095 too early or wrap to a small value, and a counter that only latches at edges would leave the stalled fan unreported. It checks that the first period after reset is discarded, so a design that trusts the partial first period would raise valid too early. It also sets the limit equal to the count and one below it, and sets it to 4095 while the count is saturated, which exposes a comparison written as greater-or-equal or a stall alarm gated by the limit.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

    localparam int TACH_CNT_W_DEF = 12;
    localparam int TACH_SYNC_DEF  = 2;
    localparam int TACH_DEB_DEF   = 3;

    // Counter phase: before the first accepted edge the partial span is thrown away
    typedef enum logic {
        PH_PRIME   = 1'b0,
        PH_MEASURE = 1'b1
    } tach_phase_e;

    // Slow-fan decision on widened operands: over the limit, or pinned at full scale
    function automatic logic tach_too_slow(
        input logic [31:0] cnt,
        input logic [31:0] lim,
        input logic [31:0] full
    );
        return (cnt > lim) || (cnt == full);
    endfunction

endpackage

// File: rtl/tach_conditioner.sv
module tach_conditioner #(
    parameter int SYNC_STAGES = fan_tach_pkg::TACH_SYNC_DEF,
    parameter int DEB_LEN     = fan_tach_pkg::TACH_DEB_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic tach_raw,
    output logic tach_rise
);

    localparam int DEB_W = (DEB_LEN > 1) ? $clog2(DEB_LEN) : 1;
    localparam logic [DEB_W-1:0] DEB_LAST = DEB_W'(DEB_LEN - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level_q;
    logic [DEB_W-1:0]       deb_q;
    logic                   sampled;

    assign sampled = sync_q[SYNC_STAGES-1];

    // Synchronizer chain
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            for (int i = SYNC_STAGES - 1; i > 0; i--) begin
                sync_q[i] <= sync_q[i-1];
            end
            sync_q[0] <= tach_raw;
        end
    end

    // Debounce: a new level must persist for DEB_LEN samples in a row
    always_ff @(posedge clk) begin
        if (rst) begin
            level_q   <= 1'b0;
            deb_q     <= '0;
            tach_rise <= 1'b0;
        end else begin
            tach_rise <= 1'b0;
            if (sampled == level_q) begin
                deb_q <= '0;
            end else if (deb_q == DEB_LAST) begin
                level_q   <= sampled;
                deb_q     <= '0;
                tach_rise <= sampled;
            end else begin
                deb_q <= deb_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tach_period_counter.sv
module tach_period_counter
    import fan_tach_pkg::*;
#(
    parameter int CNT_W = TACH_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tach_rise,
    input  logic             ref_tick,
    output logic [CNT_W-1:0] count_q,
    output logic             valid_q
);

    localparam logic [CNT_W-1:0] FULL     = '1;
    localparam logic [CNT_W-1:0] NEAR_TOP = FULL - 1'b1;

    tach_phase_e      phase_q;
    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_PRIME;
            run_q   <= '0;
            count_q <= '0;
            valid_q <= 1'b0;
        end else if (tach_rise) begin
            // Close the period; a tick in the same cycle belongs to the new one
            phase_q <= PH_MEASURE;
            run_q   <= {{(CNT_W-1){1'b0}}, ref_tick};
            if (phase_q == PH_MEASURE) begin
                count_q <= run_q;
                valid_q <= 1'b1;
            end
        end else if (ref_tick && (run_q != FULL)) begin
            run_q <= run_q + 1'b1;
            if (run_q == NEAR_TOP) begin
                // Stalled fan: publish full scale without waiting for an edge
                count_q <= FULL;
                valid_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tach_speed_compare.sv
module tach_speed_compare
    import fan_tach_pkg::*;
#(
    parameter int CNT_W = TACH_CNT_W_DEF
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic             valid_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             alarm_o
);

    localparam logic [CNT_W-1:0] FULL = '1;

    assign alarm_o = valid_i && tach_too_slow(32'(count_i), 32'(limit_i), 32'(FULL));

endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
    import fan_tach_pkg::*;
#(
    parameter int CNT_W       = TACH_CNT_W_DEF,
    parameter int SYNC_STAGES = TACH_SYNC_DEF,
    parameter int DEB_LEN     = TACH_DEB_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tach_in,
    input  logic             ref_tick,
    input  logic [CNT_W-1:0] spd_limit,
    output logic [CNT_W-1:0] count_out,
    output logic             count_valid,
    output logic             slow_alarm
);

    logic tach_rise;

    tach_conditioner #(
        .SYNC_STAGES(SYNC_STAGES),
        .DEB_LEN    (DEB_LEN)
    ) u_cond (
        .clk      (clk),
        .rst      (rst),
        .tach_raw (tach_in),
        .tach_rise(tach_rise)
    );

    tach_period_counter #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk      (clk),
        .rst      (rst),
        .tach_rise(tach_rise),
        .ref_tick (ref_tick),
        .count_q  (count_out),
        .valid_q  (count_valid)
    );

    tach_speed_compare #(
        .CNT_W(CNT_W)
    ) u_cmp (
        .count_i(count_out),
        .valid_i(count_valid),
        .limit_i(spd_limit),
        .alarm_o(slow_alarm)
    );

endmodule

// File: rtl/fan_tach_meter_chk.sv
module fan_tach_meter_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             ref_tick,
    input logic             tach_rise,
    input logic [CNT_W-1:0] count_out,
    input logic             count_valid,
    input logic             slow_alarm
);

    // R5
    valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        count_valid |=> count_valid);

    // R7
    alarm_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !count_valid |-> !slow_alarm);

    // R8
    stall_alarm_chk: assert property (@(posedge clk) disable iff (rst)
        (count_valid && (&count_out)) |-> slow_alarm);

    // R9
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tach_rise && !ref_tick) |=> $stable(count_out));

    // R4
    first_value_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(count_valid) |-> ($past(tach_rise) || (&count_out)));

endmodule

bind fan_tach_meter fan_tach_meter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ref_tick   (ref_tick),
    .tach_rise  (tach_rise),
    .count_out  (count_out),
    .count_valid(count_valid),
    .slow_alarm (slow_alarm)
);

// File: tb/test_fan_tach_meter.sv
module test_fan_tach_meter;

    localparam int CLK_PERIOD = 10;
    localparam int FULL       = 4095;
    localparam int SETTLE     = 15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tach_in = 1'b0;
    logic        ref_tick = 1'b0;
    logic [11:0] spd_limit = 12'd1000;
    logic [11:0] count_out;
    logic        count_valid;
    logic        slow_alarm;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // scoreboard queues
    int    q_due[$];
    int    q_cnt[$];
    int    q_alm[$];
    string q_tag[$];

    // reference model
    int    m_run = 0;
    bit    m_armed = 1'b0;
    int    lim_val = 1000;
    string prev_tag = "R3";

    fan_tach_meter i_fan_tach_meter (
        .clk        (clk),
        .rst        (rst),
        .tach_in    (tach_in),
        .ref_tick   (ref_tick),
        .spd_limit  (spd_limit),
        .count_out  (count_out),
        .count_valid(count_valid),
        .slow_alarm (slow_alarm)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_alarm(input int c);
        return ((c > lim_val) || (c == FULL)) ? 1 : 0;
    endfunction

    task automatic push(input int c, input string tag);
        q_due.push_back(cyc + SETTLE);
        q_cnt.push_back(c);
        q_alm.push_back(exp_alarm(c));
        q_tag.push_back(tag);
    endtask

    // monitor: pops each expected result once it is due
    always @(negedge clk) begin
        if (!rst && q_due.size() > 0 && cyc >= q_due[0]) begin
            int    c;
            int    a;
            string t;
            void'(q_due.pop_front());
            c = q_cnt.pop_front();
            a = q_alm.pop_front();
            t = q_tag.pop_front();
            chk({t, " count"}, int'(count_out), c);
            chk("R5 valid", int'(count_valid), 1);
            chk({t, " alarm"}, int'(slow_alarm), a);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tach_edge();
        @(negedge clk);
        tach_in = 1'b1;
        if (m_armed) push((m_run > FULL) ? FULL : m_run, prev_tag);
        m_armed = 1'b1;
        m_run = 0;
        idle(12);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_tick = 1'b1;
            if (m_run < FULL) begin
                m_run++;
                if (m_run == FULL) push(FULL, "R6");
            end
            @(negedge clk);
            ref_tick = 1'b0;
        end
    endtask

    // pulse of DEB_LEN-1 = 2 cycles at the given level
    task automatic glitch(input logic lvl);
        @(negedge clk);
        tach_in = lvl;
        idle(2);
        tach_in = ~lvl;
        idle(4);
    endtask

    task automatic period(input int n, input string tag, input bit with_glitch);
        tach_edge();
        prev_tag = tag;
        ticks(n / 2);
        if (with_glitch) glitch(1'b0);
        @(negedge clk);
        tach_in = 1'b0;
        idle(4);
        if (with_glitch) glitch(1'b1);
        ticks(n - n / 2);
        idle(12);
    endtask

    task automatic set_limit(input int v);
        @(negedge clk);
        lim_val = v;
        spd_limit = 12'(v);
        @(negedge clk);
    endtask

    initial begin
        int held;
        idle(5);
        chk("R1 count in reset", int'(count_out), 0);
        chk("R1 valid in reset", int'(count_valid), 0);
        rst = 1'b0;
        idle(3);
        chk("R1 count after reset", int'(count_out), 0);
        chk("R1 valid after reset", int'(count_valid), 0);
        chk("R1 alarm after reset", int'(slow_alarm), 0);

        // first span discarded
        period(100, "R4", 1'b0);
        chk("R4 valid after first period", int'(count_valid), 0);
        chk("R4 count after first period", int'(count_out), 0);

        period(300, "R3", 1'b0);
        period(1500, "R3", 1'b0);
        period(4094, "R6", 1'b0);
        period(50, "R2", 1'b1);
        period(5000, "R6", 1'b0);
        period(200, "R6", 1'b0);
        period(77, "R3", 1'b0);
        tach_edge();
        idle(20);

        // limit comparisons at count 77
        set_limit(77);
        chk("R7 equal limit no alarm", int'(slow_alarm), 0);
        set_limit(76);
        chk("R7 limit below count alarms", int'(slow_alarm), 1);
        set_limit(4000);
        chk("R7 high limit clears alarm", int'(slow_alarm), 0);

        // hold with no tick and no edge
        held = int'(count_out);
        idle(40);
        chk("R9 count held while idle", int'(count_out), held);

        // stall without any further edge
        ticks(FULL);
        idle(20);
        set_limit(4095);
        chk("R8 stall alarms at max limit", int'(slow_alarm), 1);
        chk("R8 stalled count", int'(count_out), FULL);

        idle(20);
        if (q_due.size() != 0) chk("scoreboard drained", q_due.size(), 0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule